// File: doc/BRIEF.md
# Banked Register-File Operand Collector

This block sits between instruction issue and a register file made of several single-ported banks. Each issued instruction carries a tag and up to three source register numbers, each with its own valid bit. The block parks the instruction in a free collector entry and raises read requests toward the banks. It arbitrates so that every bank serves at most one read per cycle. Returned data is written into the matching operand slot of the entry.

Once every valid source of an entry has arrived, the entry may dispatch its tag and operands to execution. When several entries are complete, the one accepted earliest goes first. Operand fetch is thereby decoupled from issue. Reads that collide on a bank are spread over successive cycles, and reads to different banks of the same instruction go out together.

Top module: `opnd_collector`

## Requirements
- R1: A source register r is read from bank r mod 4 at row r div 4. That bank's request valid bit is raised and the row appears on its row field.
- R2: Each bank receives at most one read request per cycle. Sources that map to one bank are requested in successive cycles. With three valid sources on distinct banks and an otherwise idle block, dispatch valid is seen two cycles after the accepting edge. With all three sources on one bank, it is seen four cycles after that edge.
- R3: Read data is presented by the bank one cycle after its request. It is captured into the operand slot that made the request.
- R4: An entry dispatches only when all of its valid sources have arrived. An instruction with no valid source is dispatchable in the cycle after acceptance. Operands leave in slot order, with slot 0 in the low 32 bits, and every slot whose source is not valid dispatches as zero.
- R5: When several entries are complete, the entry accepted earliest dispatches first, regardless of which entry index it occupies.
- R6: Issue ready is low whenever all four entries are occupied. An issue offered while ready is low is not accepted and never dispatches.
- R7: Bank arbitration rotates over the entries. After an entry is granted a bank, other entries waiting for that bank are granted before it is granted again.
- R8: The dispatched tag is the tag given with the instruction at issue, and it accompanies that instruction's own operands.
- R9: While dispatch ready is low, dispatch valid stays high and the entry keeps its contents.
- R10: An entry is freed by its dispatch. Issue ready returns in the cycle after a dispatch from a full collector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction offered |
| issueReady | output | 1 | A collector entry is free |
| issueTag | input | TAG_W | Instruction tag |
| issueSrcValid | input | 3 | Per-slot source valid |
| issueSrcReg | input | 3 x REG_W | Per-slot source register number |
| bankReqValid | output | 4 | Per-bank read request |
| bankReqRow | output | 4 x (REG_W-2) | Per-bank row address |
| bankRdData | input | 4 x DATA_W | Per-bank read data, one cycle after request |
| dispValid | output | 1 | A complete entry is offered |
| dispReady | input | 1 | Execution accepts the offer |
| dispTag | output | TAG_W | Tag of the dispatched instruction |
| dispOperands | output | 3 x DATA_W | Operands, slot 0 in the low bits |

## Verification
The bench targets three cases. In the first, three reads hit one bank; a design that lets them overlap would corrupt operands or dispatch too early, and the exact four-cycle latency exposes it. In the second, an older entry sits at a higher index than a newer complete one; a lowest-index dispatcher would send the newer tag first. In the third, a young entry waits behind an older one on a busy bank, and a fixed-priority arbiter would keep it waiting until the older entry had all its reads. Random traffic with back-pressure, plus an issue held while the collector is full, checks every operand against a model of the banks and shows that a refused issue never dispatches.

// File: rtl/oc_pkg.sv
package oc_pkg;
  parameter int unsigned OC_ENTRIES = 4;
  parameter int unsigned OC_BANKS   = 4;
  parameter int unsigned OC_SRCS    = 3;

  localparam int unsigned ENT_W  = $clog2(OC_ENTRIES);
  localparam int unsigned BANK_W = $clog2(OC_BANKS);
  localparam int unsigned SLOT_W = $clog2(OC_SRCS);

  // strobes from control to datapath
  typedef struct packed {
    logic                               allocEn;
    logic [ENT_W-1:0]                   allocIdx;
    logic [OC_BANKS-1:0]                grantEn;
    logic [OC_BANKS-1:0][ENT_W-1:0]     grantEnt;
    logic [OC_BANKS-1:0][SLOT_W-1:0]    grantSlot;
    logic [OC_BANKS-1:0]                capEn;
    logic [OC_BANKS-1:0][ENT_W-1:0]     capEnt;
    logic [OC_BANKS-1:0][SLOT_W-1:0]    capSlot;
    logic [ENT_W-1:0]                   dispIdx;
  } ocStrobe_t;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                issueValid,
  input  logic [OC_SRCS-1:0]                  issueSrcValid,
  input  logic [OC_SRCS-1:0][BANK_W-1:0]      issueSrcBank,
  input  logic                                dispReady,
  output logic                                issueReady,
  output logic                                dispValid,
  output ocStrobe_t                           strobe
);
  logic [OC_ENTRIES-1:0]                           busy;
  logic [OC_ENTRIES-1:0][OC_SRCS-1:0]              pend;
  logic [OC_ENTRIES-1:0][OC_SRCS-1:0]              have;
  logic [OC_ENTRIES-1:0][OC_SRCS-1:0][BANK_W-1:0]  bankOf;
  logic [OC_ENTRIES-1:0][OC_ENTRIES-1:0]           older;   // older[j][i]: j accepted before i
  logic [OC_BANKS-1:0][ENT_W-1:0]                  rrPtr;
  logic [OC_BANKS-1:0]                             capEn;
  logic [OC_BANKS-1:0][ENT_W-1:0]                  capEnt;
  logic [OC_BANKS-1:0][SLOT_W-1:0]                 capSlot;

  logic                                            anyFree;
  logic [ENT_W-1:0]                                freeIdx;
  logic                                            accept;
  logic [OC_BANKS-1:0]                             grantEn;
  logic [OC_BANKS-1:0][ENT_W-1:0]                  grantEnt;
  logic [OC_BANKS-1:0][SLOT_W-1:0]                 grantSlot;
  logic [OC_ENTRIES-1:0]                           entReady;
  logic [OC_ENTRIES-1:0]                           selOne;
  logic [ENT_W-1:0]                                dispIdx;
  logic                                            fire;

  // lowest free entry
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int e = OC_ENTRIES - 1; e >= 0; e--) begin
      if (!busy[e]) begin
        anyFree = 1'b1;
        freeIdx = ENT_W'(e);
      end
    end
  end

  assign issueReady = anyFree;
  assign accept     = issueValid & anyFree;

  // per-bank rotating arbiter over entries, lowest slot inside an entry
  always_comb begin
    logic [ENT_W-1:0]  cand;
    logic              hit;
    logic [SLOT_W-1:0] hs;
    grantEn   = '0;
    grantEnt  = '0;
    grantSlot = '0;
    for (int b = 0; b < OC_BANKS; b++) begin
      for (int k = 0; k < OC_ENTRIES; k++) begin
        cand = rrPtr[b] + ENT_W'(k);
        hit  = 1'b0;
        hs   = '0;
        for (int s = OC_SRCS - 1; s >= 0; s--) begin
          if (pend[cand][s] && (bankOf[cand][s] == BANK_W'(b))) begin
            hit = 1'b1;
            hs  = SLOT_W'(s);
          end
        end
        if (hit && !grantEn[b]) begin
          grantEn[b]   = 1'b1;
          grantEnt[b]  = cand;
          grantSlot[b] = hs;
        end
      end
    end
  end

  // oldest complete entry
  always_comb begin
    for (int e = 0; e < OC_ENTRIES; e++) entReady[e] = busy[e] & (&have[e]);
  end

  always_comb begin
    selOne = '0;
    for (int i = 0; i < OC_ENTRIES; i++) begin
      selOne[i] = entReady[i];
      for (int j = 0; j < OC_ENTRIES; j++) begin
        if ((j != i) && entReady[j] && older[j][i]) selOne[i] = 1'b0;
      end
    end
    dispIdx = '0;
    for (int i = 0; i < OC_ENTRIES; i++) begin
      if (selOne[i]) dispIdx = ENT_W'(i);
    end
  end

  assign dispValid = |selOne;
  assign fire      = dispValid & dispReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= '0;
      pend    <= '0;
      have    <= '0;
      bankOf  <= '0;
      older   <= '0;
      rrPtr   <= '0;
      capEn   <= '0;
      capEnt  <= '0;
      capSlot <= '0;
    end else begin
      capEn   <= grantEn;
      capEnt  <= grantEnt;
      capSlot <= grantSlot;
      for (int b = 0; b < OC_BANKS; b++) begin
        if (grantEn[b]) begin
          pend[grantEnt[b]][grantSlot[b]] <= 1'b0;
          rrPtr[b] <= grantEnt[b] + ENT_W'(1);
        end
        if (capEn[b]) have[capEnt[b]][capSlot[b]] <= 1'b1;
      end
      if (fire) busy[dispIdx] <= 1'b0;
      if (accept) begin
        busy[freeIdx]   <= 1'b1;
        pend[freeIdx]   <= issueSrcValid;
        have[freeIdx]   <= ~issueSrcValid;
        bankOf[freeIdx] <= issueSrcBank;
        for (int j = 0; j < OC_ENTRIES; j++) older[j][freeIdx] <= 1'b1;
        for (int j = 0; j < OC_ENTRIES; j++) older[freeIdx][j] <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.allocEn   = accept;
    strobe.allocIdx  = freeIdx;
    strobe.grantEn   = grantEn;
    strobe.grantEnt  = grantEnt;
    strobe.grantSlot = grantSlot;
    strobe.capEn     = capEn;
    strobe.capEnt    = capEnt;
    strobe.capSlot   = capSlot;
    strobe.dispIdx   = dispIdx;
  end

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ((&busy) && !fire) |=> (&busy)); // R6

  AST_DISP_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (busy[dispIdx] && (pend[dispIdx] == '0) && (&have[dispIdx]))); // R4

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady) |=> dispValid); // R9

  for (genvar b = 0; b < OC_BANKS; b++) begin : g_chk
    AST_CAP_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
      capEn[b] |-> (busy[capEnt[b]] && !have[capEnt[b]][capSlot[b]]
                    && !pend[capEnt[b]][capSlot[b]])); // R3
    for (genvar c = b + 1; c < OC_BANKS; c++) begin : g_pair
      AST_SLOT_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
        (grantEn[b] && grantEn[c]) |-> ((grantEnt[b] != grantEnt[c])
                                        || (grantSlot[b] != grantSlot[c]))); // R2
    end
  end
endmodule

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
#(
  parameter int unsigned REG_W  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned ROW_W = REG_W - BANK_W
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ocStrobe_t                             strobe,
  input  logic [TAG_W-1:0]                      issueTag,
  input  logic [OC_SRCS-1:0][REG_W-1:0]         issueSrcReg,
  input  logic [OC_BANKS-1:0][DATA_W-1:0]       bankRdData,
  output logic [OC_BANKS-1:0][ROW_W-1:0]        bankReqRow,
  output logic [TAG_W-1:0]                      dispTag,
  output logic [OC_SRCS-1:0][DATA_W-1:0]        dispOperands
);
  logic [OC_ENTRIES-1:0][OC_SRCS-1:0][ROW_W-1:0]  srcRow;
  logic [OC_ENTRIES-1:0][TAG_W-1:0]               tagQ;
  logic [OC_ENTRIES-1:0][OC_SRCS-1:0][DATA_W-1:0] opnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcRow <= '0;
      tagQ   <= '0;
      opnd   <= '0;
    end else begin
      for (int b = 0; b < OC_BANKS; b++) begin
        if (strobe.capEn[b]) opnd[strobe.capEnt[b]][strobe.capSlot[b]] <= bankRdData[b];
      end
      if (strobe.allocEn) begin
        for (int s = 0; s < OC_SRCS; s++)
          srcRow[strobe.allocIdx][s] <= issueSrcReg[s][REG_W-1:BANK_W];
        tagQ[strobe.allocIdx] <= issueTag;
        opnd[strobe.allocIdx] <= '0;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < OC_BANKS; b++) begin
      bankReqRow[b] = strobe.grantEn[b] ? srcRow[strobe.grantEnt[b]][strobe.grantSlot[b]] : '0;
    end
  end

  assign dispTag      = tagQ[strobe.dispIdx];
  assign dispOperands = opnd[strobe.dispIdx];
endmodule

// File: rtl/opnd_collector.sv
module opnd_collector
  import oc_pkg::*;
#(
  parameter int unsigned REG_W  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned ROW_W = REG_W - BANK_W
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  issueValid,
  output logic                                  issueReady,
  input  logic [TAG_W-1:0]                      issueTag,
  input  logic [OC_SRCS-1:0]                    issueSrcValid,
  input  logic [OC_SRCS-1:0][REG_W-1:0]         issueSrcReg,
  output logic [OC_BANKS-1:0]                   bankReqValid,
  output logic [OC_BANKS-1:0][ROW_W-1:0]        bankReqRow,
  input  logic [OC_BANKS-1:0][DATA_W-1:0]       bankRdData,
  output logic                                  dispValid,
  input  logic                                  dispReady,
  output logic [TAG_W-1:0]                      dispTag,
  output logic [OC_SRCS-1:0][DATA_W-1:0]        dispOperands
);
  ocStrobe_t                          strobe;
  logic [OC_SRCS-1:0][BANK_W-1:0]     issueSrcBank;

  for (genvar s = 0; s < OC_SRCS; s++) begin : g_bank
    assign issueSrcBank[s] = issueSrcReg[s][BANK_W-1:0];
  end

  oc_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .issueValid    (issueValid),
    .issueSrcValid (issueSrcValid),
    .issueSrcBank  (issueSrcBank),
    .dispReady     (dispReady),
    .issueReady    (issueReady),
    .dispValid     (dispValid),
    .strobe        (strobe)
  );

  oc_datapath #(.REG_W(REG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .issueTag     (issueTag),
    .issueSrcReg  (issueSrcReg),
    .bankRdData   (bankRdData),
    .bankReqRow   (bankReqRow),
    .dispTag      (dispTag),
    .dispOperands (dispOperands)
  );

  assign bankReqValid = strobe.grantEn;
endmodule

// File: tb/opnd_collector_tb_top.sv
module opnd_collector_tb_top;
  import oc_pkg::*;
  localparam int unsigned REG_W  = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned ROW_W  = REG_W - BANK_W;

  logic clk = 1'b0;
  logic rstN;
  logic issueValid, issueReady, dispValid, dispReady;
  logic [TAG_W-1:0] issueTag, dispTag;
  logic [OC_SRCS-1:0] issueSrcValid;
  logic [OC_SRCS-1:0][REG_W-1:0] issueSrcReg;
  logic [OC_BANKS-1:0] bankReqValid;
  logic [OC_BANKS-1:0][ROW_W-1:0] bankReqRow;
  logic [OC_BANKS-1:0][DATA_W-1:0] bankRdData;
  logic [OC_SRCS-1:0][DATA_W-1:0] dispOperands;

  int checks = 0;
  int failures = 0;
  int dispCount = 0;
  int issueCount = 0;
  logic [TAG_W-1:0] dispLog [0:4095];
  logic [OC_SRCS-1:0][DATA_W-1:0] expOps [0:15];
  bit outstanding [0:15];

  always #5 clk = ~clk;

  opnd_collector dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .issueTag(issueTag), .issueSrcValid(issueSrcValid), .issueSrcReg(issueSrcReg),
    .bankReqValid(bankReqValid), .bankReqRow(bankReqRow), .bankRdData(bankRdData),
    .dispValid(dispValid), .dispReady(dispReady), .dispTag(dispTag),
    .dispOperands(dispOperands)
  );

  function automatic logic [DATA_W-1:0] regValue(input logic [REG_W-1:0] r);
    return 32'hA5A5_0000 ^ ({26'd0, r} * 32'h0103_0507);
  endfunction

  // single-ported bank model: one-cycle read latency
  always_ff @(posedge clk) begin
    for (int b = 0; b < OC_BANKS; b++)
      if (bankReqValid[b]) bankRdData[b] <= regValue({bankReqRow[b], BANK_W'(b)});
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: records accepted issues, checks every dispatch (R1 R3 R4 R8)
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (dispValid && dispReady) begin
        chk(outstanding[dispTag], "R8", 128'(dispTag), 128'(dispTag));
        chk(dispOperands == expOps[dispTag], "R4", 128'(dispOperands), 128'(expOps[dispTag]));
        outstanding[dispTag] = 1'b0;
        dispLog[dispCount] = dispTag;
        dispCount++;
      end
      if (issueValid && issueReady) begin
        for (int s = 0; s < OC_SRCS; s++)
          expOps[issueTag][s] = issueSrcValid[s] ? regValue(issueSrcReg[s]) : '0;
        outstanding[issueTag] = 1'b1;
        issueCount++;
      end
    end
  end

  task automatic drive(input int tag, input logic [2:0] v, input int r0, input int r1, input int r2);
    @(negedge clk);
    issueValid = 1'b1;
    issueTag = TAG_W'(tag);
    issueSrcValid = v;
    issueSrcReg[0] = REG_W'(r0);
    issueSrcReg[1] = REG_W'(r1);
    issueSrcReg[2] = REG_W'(r2);
  endtask

  task automatic issueOne(input int tag, input logic [2:0] v, input int r0, input int r1, input int r2);
    drive(tag, v, r0, r1, r2);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  // called at the negedge after the accepting edge; cycles until dispValid
  task automatic waitDisp(output int k);
    k = 0;
    #2;
    while (!dispValid && k < 20) begin
      @(negedge clk); #2;
      k++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int k;
    int base;
    int nextTag;
    void'($urandom(32'd20240611));
    for (int t = 0; t < 16; t++) outstanding[t] = 1'b0;
    rstN = 1'b0; issueValid = 1'b0; issueTag = '0; issueSrcValid = '0;
    issueSrcReg = '0; dispReady = 1'b0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(issueReady == 1'b1, "R6", 128'(issueReady), 128'(1));
    chk(dispValid == 1'b0, "R4", 128'(dispValid), 128'(0));
    chk(bankReqValid == '0, "R2", 128'(bankReqValid), 128'(0));

    // R1 / R2: distinct banks, parallel reads
    dispReady = 1'b1;
    issueOne(0, 3'b111, 29, 6, 3);
    #1;
    chk(bankReqValid == 4'b1110, "R1", 128'(bankReqValid), 128'(4'b1110));
    chk(bankReqRow[1] == 4'd7, "R1", 128'(bankReqRow[1]), 128'(7));
    chk(bankReqRow[2] == 4'd1 && bankReqRow[3] == 4'd0, "R1",
        128'({bankReqRow[2], bankReqRow[3]}), 128'({4'd1, 4'd0}));
    waitDisp(k);
    chk(k == 2, "R2", 128'(k), 128'(2));
    idle(2);

    // R2: three reads to one bank are serialized
    issueOne(1, 3'b111, 4, 8, 12);
    #1;
    chk(bankReqValid == 4'b0001 && bankReqRow[0] == 4'd1, "R2",
        128'({bankReqValid, bankReqRow[0]}), 128'({4'b0001, 4'd1}));
    waitDisp(k);
    chk(k == 4, "R2", 128'(k), 128'(4));
    idle(2);

    // R4: no sources and a single middle source
    issueOne(2, 3'b000, 0, 0, 0);
    waitDisp(k);
    chk(k == 0, "R4", 128'(k), 128'(0));
    idle(2);
    issueOne(3, 3'b010, 0, 9, 0);
    waitDisp(k);
    chk(k == 2, "R4", 128'(k), 128'(2));
    idle(3);

    // R7: young entry on a contended bank is not starved
    base = dispCount;
    drive(4, 3'b111, 0, 4, 8);
    drive(5, 3'b001, 12, 0, 0);
    @(negedge clk); issueValid = 1'b0;
    idle(10);
    chk(dispCount == base + 2, "R7", 128'(dispCount - base), 128'(2));
    chk(dispLog[base] == 4'd5 && dispLog[base + 1] == 4'd4, "R7",
        128'({dispLog[base], dispLog[base + 1]}), 128'({4'd5, 4'd4}));

    // R5 / R9: oldest complete entry first, held under back-pressure
    dispReady = 1'b0;
    base = dispCount;
    issueOne(6, 3'b001, 1, 0, 0);
    issueOne(7, 3'b001, 2, 0, 0);
    idle(4); #2;
    chk(dispValid == 1'b1 && dispTag == 4'd6, "R9", 128'({dispValid, dispTag}), 128'({1'b1, 4'd6}));
    @(negedge clk); dispReady = 1'b1;
    @(negedge clk); dispReady = 1'b0;
    issueOne(8, 3'b001, 3, 0, 0);
    idle(4); #2;
    chk(dispValid == 1'b1 && dispTag == 4'd7, "R5", 128'({dispValid, dispTag}), 128'({1'b1, 4'd7}));
    @(negedge clk); dispReady = 1'b1;
    idle(4);
    chk(dispLog[base] == 4'd6 && dispLog[base + 1] == 4'd7 && dispLog[base + 2] == 4'd8, "R5",
        128'({dispLog[base], dispLog[base + 1], dispLog[base + 2]}), 128'({4'd6, 4'd7, 4'd8}));

    // R6 / R10: full collector refuses issue
    dispReady = 1'b0;
    base = dispCount;
    drive(9, 3'b011, 5, 10, 0);
    drive(10, 3'b100, 0, 0, 15);
    drive(11, 3'b111, 16, 17, 18);
    drive(12, 3'b001, 20, 0, 0);
    drive(13, 3'b001, 21, 0, 0);
    #2;
    chk(issueReady == 1'b0, "R6", 128'(issueReady), 128'(0));
    idle(3);
    issueValid = 1'b0;
    idle(4);
    dispReady = 1'b1;
    @(negedge clk); #2;
    chk(issueReady == 1'b1, "R10", 128'(issueReady), 128'(1));
    idle(10);
    chk(dispCount == base + 4, "R6", 128'(dispCount - base), 128'(4));
    chk(outstanding[13] == 1'b0, "R6", 128'(outstanding[13]), 128'(0));

    // random traffic with back-pressure
    nextTag = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      issueValid = ($urandom % 3) != 0;
      issueTag = TAG_W'(nextTag);
      issueSrcValid = 3'($urandom);
      for (int s = 0; s < OC_SRCS; s++) issueSrcReg[s] = REG_W'($urandom);
      dispReady = ($urandom % 4) != 0;
      #1;
      if (issueValid && issueReady) nextTag = (nextTag + 1) % 16;
    end
    @(negedge clk);
    issueValid = 1'b0;
    dispReady = 1'b1;
    idle(20);
    chk(dispCount == issueCount, "R10", 128'(dispCount), 128'(issueCount));
    finishRun();
  end
endmodule